// File: doc/BRIEF.md
# Endian-Aware Load Data Aligner

This block sits on the read path of a processor, between a 32-bit memory data bus and the register write port. It takes the raw word read from the word-aligned address, the two low address bits, a transfer size code and a static endian-mode input. It returns the value to be written into the destination register.

For a word load at an unaligned offset, the block rotates the word. For a byte or halfword load, it picks the addressed lane or lanes and zero-extends the result. A separate size code serves 16-bit instruction fetches: the halfword at the lower address is delivered first, then the higher one.

The block is combinational. A parameter `OUT_REG` adds an output register, and is on by default. Sign extension and the bus protocol are handled elsewhere.

Top module: `load_aligner`

## Requirements
- R1: While `rst_n` is low, `load_data` is 0. With `OUT_REG`=1, the result for inputs sampled at a rising clock edge appears on `load_data` after that edge.
- R2: A word load (`size`=2'b10) at offset 0 returns `rd_word` unchanged, with bus bit 31 in result bit 31, in both endian modes.
- R3: In little-endian mode (`big_endian`=0), a word load at offset k rotates `rd_word` right by 8·k bits. For 0x76543210, offsets 1, 2 and 3 give 0x10765432, 0x32107654 and 0x54321076.
- R4: In big-endian mode (`big_endian`=1), a word load at offset k rotates `rd_word` left by 8·k bits. For 0x76543210, offsets 1, 2 and 3 give 0x54321076, 0x32107654 and 0x10765432.
- R5: In little-endian mode, a byte load (`size`=2'b00) at offset k returns byte lane k (bits 8k+7:8k). For 0x76543210 this gives 0x10, 0x32, 0x54 and 0x76.
- R6: In big-endian mode, a byte load at offset k returns byte lane 3-k. For 0x76543210 this gives 0x76, 0x54, 0x32 and 0x10.
- R7: In little-endian mode, a halfword load (`size`=2'b01) returns bits 15:0 at offset 0 and bits 31:16 at offset 2.
- R8: In big-endian mode, a halfword load returns bits 31:16 at offset 0 and bits 15:0 at offset 2.
- R9: A halfword load or instruction fetch at an odd offset (1 or 3) returns the same value as the even offset one below it.
- R10: An instruction halfword fetch (`size`=2'b11) returns, at offset 0, the lower-addressed halfword of the word and, at offset 2, the higher-addressed one. That is bits 15:0 then 31:16 in little-endian mode, and bits 31:16 then 15:0 in big-endian mode.
- R11: Byte results have bits 31:8 equal to 0, and halfword and fetch results have bits 31:16 equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| rd_word | input | 32 | Word read from the word-aligned address |
| addr_lo | input | 2 | Byte offset of the access within the word |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 instruction halfword fetch |
| big_endian | input | 1 | Endian mode: 1 big-endian, 0 little-endian |
| load_data | output | 32 | Aligned and zero-extended load result |

## Verification
With the default output register, every result is due one rising edge after the inputs are presented. The inputs are not registered, so no other latency is involved.

The bench changes the inputs on a falling edge, lets one rising edge capture them, and reads `load_data` on the next falling edge. Each sample is therefore taken half a cycle away from any edge. The checker's properties look back exactly one cycle, and only when the previous cycle was already out of reset.

// File: rtl/load_aligner.sv
module load_aligner #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rd_word,
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic        big_endian,
  output logic [31:0] load_data
);
  localparam logic [1:0] SZ_BYTE  = 2'b00;
  localparam logic [1:0] SZ_HALF  = 2'b01;
  localparam logic [1:0] SZ_WORD  = 2'b10;

  logic [4:0]  sh;
  logic [5:0]  sh_inv;
  logic [31:0] rot_r, rot_l;
  logic [1:0]  lane;
  logic        upper_half;
  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic [31:0] aligned;

  assign sh         = {addr_lo, 3'b000};
  assign sh_inv     = 6'd32 - {1'b0, sh};
  assign rot_r      = (rd_word >> sh) | (rd_word << sh_inv);
  assign rot_l      = (rd_word << sh) | (rd_word >> sh_inv);
  assign lane       = big_endian ? ~addr_lo : addr_lo;
  assign upper_half = addr_lo[1] ^ big_endian;
  assign half_v     = upper_half ? rd_word[31:16] : rd_word[15:0];

  always_comb begin
    case (lane)
      2'd0:    byte_v = rd_word[7:0];
      2'd1:    byte_v = rd_word[15:8];
      2'd2:    byte_v = rd_word[23:16];
      default: byte_v = rd_word[31:24];
    endcase
  end

  always_comb begin
    case (size)
      SZ_BYTE: aligned = {24'd0, byte_v};
      SZ_HALF: aligned = {16'd0, half_v};
      SZ_WORD: aligned = big_endian ? rot_l : rot_r;
      default: aligned = {16'd0, half_v};
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) load_data <= '0;
        else        load_data <= aligned;
      end
    end else begin : g_comb
      assign load_data = rst_n ? aligned : '0;
    end
  endgenerate
endmodule

// File: rtl/load_aligner_chk.sv
module load_aligner_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_word,
  input logic [1:0]  addr_lo,
  input logic [1:0]  size,
  input logic        big_endian,
  input logic [31:0] load_data
);
  generate
    if (OUT_REG) begin : g_reg
      // R1
      reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> load_data == 32'd0);
      // R2
      aligned_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size) == 2'b10 && $past(addr_lo) == 2'b00)
        |-> load_data == $past(rd_word));
      // R3
      word_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size) == 2'b10)
        |-> $countones(load_data) == $countones($past(rd_word)));
      // R11
      byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size) == 2'b00) |-> load_data[31:8] == 24'd0);
      // R11
      half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size[0])) |-> load_data[31:16] == 16'd0);
      // R10
      fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size) == 2'b11 && $past(addr_lo) == 2'b00)
        |-> load_data[15:0] == ($past(big_endian) ? $past(rd_word[31:16])
                                                  : $past(rd_word[15:0])));
    end else begin : g_comb
      // R2
      aligned_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b10 && addr_lo == 2'b00) |-> load_data == rd_word);
      // R3
      word_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b10) |-> $countones(load_data) == $countones(rd_word));
      // R11
      byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 2'b00) |-> load_data[31:8] == 24'd0);
      // R11
      half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size[0] |-> load_data[31:16] == 16'd0);
    end
  endgenerate
endmodule

bind load_aligner load_aligner_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .addr_lo(addr_lo),
  .size(size), .big_endian(big_endian), .load_data(load_data)
);

// File: tb/tb_load_aligner.sv
module tb_load_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rd_word = 32'h0;
  logic [1:0]  addr_lo = 2'd0;
  logic [1:0]  size = 2'd0;
  logic        big_endian = 1'b0;
  logic [31:0] load_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  load_aligner dut (
    .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .addr_lo(addr_lo),
    .size(size), .big_endian(big_endian), .load_data(load_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] w, input logic [1:0] a, input logic [1:0] s,
                      input logic be, input string req, input logic [31:0] exp);
    @(negedge clk);
    rd_word = w; addr_lo = a; size = s; big_endian = be;
    @(posedge clk);
    @(negedge clk);
    check(req, load_data, exp);
  endtask

  task automatic t_reset;
    rd_word = 32'h76543210; size = 2'b10;
    repeat (3) @(negedge clk);
    check("R1 reset", load_data, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 latency", load_data, 32'h76543210);
  endtask

  task automatic t_words;
    load(32'h76543210, 2'd0, 2'b10, 1'b0, "R2 le", 32'h76543210);
    load(32'h76543210, 2'd0, 2'b10, 1'b1, "R2 be", 32'h76543210);
    load(32'h76543210, 2'd1, 2'b10, 1'b0, "R3 off1", 32'h10765432);
    load(32'h76543210, 2'd2, 2'b10, 1'b0, "R3 off2", 32'h32107654);
    load(32'h76543210, 2'd3, 2'b10, 1'b0, "R3 off3", 32'h54321076);
    load(32'h76543210, 2'd1, 2'b10, 1'b1, "R4 off1", 32'h54321076);
    load(32'h76543210, 2'd2, 2'b10, 1'b1, "R4 off2", 32'h32107654);
    load(32'h76543210, 2'd3, 2'b10, 1'b1, "R4 off3", 32'h10765432);
  endtask

  task automatic t_bytes;
    logic [7:0] le_exp [4] = '{8'h10, 8'h32, 8'h54, 8'h76};
    for (int k = 0; k < 4; k++) begin
      load(32'h76543210, 2'(k), 2'b00, 1'b0, "R5 le byte", {24'd0, le_exp[k]});
      load(32'h76543210, 2'(k), 2'b00, 1'b1, "R6 be byte", {24'd0, le_exp[3-k]});
    end
    load(32'hF1E2D3C4, 2'd3, 2'b00, 1'b0, "R11 byte zext", 32'h000000F1);
  endtask

  task automatic t_halves;
    load(32'h76543210, 2'd0, 2'b01, 1'b0, "R7 off0", 32'h00003210);
    load(32'h76543210, 2'd2, 2'b01, 1'b0, "R7 off2", 32'h00007654);
    load(32'h76543210, 2'd0, 2'b01, 1'b1, "R8 off0", 32'h00007654);
    load(32'h76543210, 2'd2, 2'b01, 1'b1, "R8 off2", 32'h00003210);
    load(32'h76543210, 2'd1, 2'b01, 1'b0, "R9 le off1", 32'h00003210);
    load(32'h76543210, 2'd3, 2'b01, 1'b0, "R9 le off3", 32'h00007654);
    load(32'h76543210, 2'd1, 2'b01, 1'b1, "R9 be off1", 32'h00007654);
    load(32'h76543210, 2'd3, 2'b01, 1'b1, "R9 be off3", 32'h00003210);
    load(32'hA1B2C3D4, 2'd2, 2'b01, 1'b0, "R11 half zext", 32'h0000A1B2);
  endtask

  task automatic t_fetch;
    load(32'hE000B510, 2'd0, 2'b11, 1'b0, "R10 le first", 32'h0000B510);
    load(32'hE000B510, 2'd2, 2'b11, 1'b0, "R10 le second", 32'h0000E000);
    load(32'hE000B510, 2'd0, 2'b11, 1'b1, "R10 be first", 32'h0000E000);
    load(32'hE000B510, 2'd2, 2'b11, 1'b1, "R10 be second", 32'h0000B510);
    load(32'hE000B510, 2'd3, 2'b11, 1'b0, "R9 fetch off3", 32'h0000E000);
  endtask

  initial begin
    t_reset();
    t_words();
    t_bytes();
    t_halves();
    t_fetch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule